// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block is the interrupt register group of a UART-style peripheral. Narrow event pulses from the receive FIFO, transmit and modem logic set bits in a sticky raw status word. Software reaches the block through a simple 32-bit register bus. Over that bus it sets an enable mask, reads the raw status and the masked status, and clears raw bits by writing ones to a clear register. The same register window also holds the two baud divisor registers, the FIFO-level register and eight read-only identification bytes at the top of the 4 KiB window.

There are six interrupt outputs. Five of them each cover one class of source: receive, transmit, receive timeout, modem status and error. The sixth is a combined line that covers every class. All six are flops, so they follow the masked status one clock later. A write to the transmit data register counts as a transmit event and sets the transmit bit.

Top module: `uirq_unit`

## Requirements
- R1: After reset the raw status, the enable mask and both divisors read 0, the FIFO-level register (byte 0x028) reads 0x12, and all six interrupt outputs are 0.
- R2: A 1 on any bit of `evt_set` in a cycle sets that raw status bit. The bit stays set until it is cleared. Bit map: 0 receive, 1 transmit, 2 receive timeout, 3..6 error, 7..10 modem status. The raw status is read at byte offset 0x014.
- R3: The masked status at byte 0x018 reads as raw status AND enable mask. The enable mask is at byte 0x010.
- R4: A write to the clear register at byte 0x01C clears each raw bit that is 1 in the written value. A source event in the same cycle wins over the clear. The clear register always reads 0.
- R5: Writes to the raw status and masked status registers leave the raw status unchanged.
- R6: Every write to the transmit data register at byte 0x000 sets raw bit 1.
- R7: Each per-class output equals the OR of (raw AND mask) over its class bits. `irq_all` equals the OR over all classes. Each output changes exactly one clock after the status that drives it changes.
- R8: A write to the enable mask changes the outputs on the clock after the mask register updates.
- R9: Byte offsets 0xFE0 to 0xFFC, one byte per word, read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order.
- R10: The integer divisor at byte 0x020 keeps 16 bits. The fractional divisor at byte 0x024 keeps 6 bits. The higher written bits read back as 0.
- R11: A read from an unmapped offset returns 0, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | 11 | Event pulses that set raw status bits |
| irq_all | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive class interrupt |
| irq_tx | output | 1 | Transmit class interrupt |
| irq_rt | output | 1 | Receive timeout class interrupt |
| irq_ms | output | 1 | Modem status class interrupt |
| irq_err | output | 1 | Error class interrupt |

## Verification
The bench fires an event and a clear on the same bit in the same cycle. A design that gives the clear priority would lose that event for good. It samples the outputs both in the cycle straight after a status change and in the cycle after that, so an output path that is combinational or two flops deep is caught. Writes to the two status registers and to an unmapped offset are each followed by a read-back, which shows any design that lets those writes modify state. The divisors are written with oversized values to catch missing width limits, and the identification bytes at both ends of the window are read to catch a wrong byte order.

// File: rtl/uirq_pkg.sv
// Package: shared constants for the UART interrupt unit.
// Holds the register word indices, the bit map of interrupt sources, the class masks and the identification bytes.
package uirq_pkg;
    localparam int ADDR_W  = 12;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 11;
    localparam int IDIV_W  = 16;
    localparam int FDIV_W  = 6;
    localparam int LVL_W   = 6;
    localparam logic [LVL_W-1:0] LVL_RESET = 6'h12;

    // Word indices (byte offset / 4)
    localparam logic [WIDX_W-1:0] W_TXDATA = 10'h000;
    localparam logic [WIDX_W-1:0] W_MASK   = 10'h004;
    localparam logic [WIDX_W-1:0] W_RAW    = 10'h005;
    localparam logic [WIDX_W-1:0] W_MASKED = 10'h006;
    localparam logic [WIDX_W-1:0] W_CLR    = 10'h007;
    localparam logic [WIDX_W-1:0] W_IDIV   = 10'h008;
    localparam logic [WIDX_W-1:0] W_FDIV   = 10'h009;
    localparam logic [WIDX_W-1:0] W_LVL    = 10'h00A;
    localparam logic [WIDX_W-1:0] W_IDBASE = 10'h3F8;

    // Source bit map
    localparam int B_RX     = 0;
    localparam int B_TX     = 1;
    localparam int B_RT     = 2;
    localparam int B_ERR_LO = 3;
    localparam int B_ERR_HI = 6;
    localparam int B_MS_LO  = 7;
    localparam int B_MS_HI  = 10;

    typedef enum int {CLS_RX = 0, CLS_TX = 1, CLS_RT = 2, CLS_MS = 3, CLS_ERR = 4} irq_cls_e;
    localparam int NUM_CLS = 5;

    // Bit range [lo, hi] that belongs to one class
    function automatic logic [NUM_SRC-1:0] range_mask(input int lo, input int hi);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Source bits that drive the output of class c
    function automatic logic [NUM_SRC-1:0] class_mask(input int c);
        case (c)
            CLS_RX:  return range_mask(B_RX, B_RX);
            CLS_TX:  return range_mask(B_TX, B_TX);
            CLS_RT:  return range_mask(B_RT, B_RT);
            CLS_MS:  return range_mask(B_MS_LO, B_MS_HI);
            default: return range_mask(B_ERR_LO, B_ERR_HI);
        endcase
    endfunction

    // Identification byte held at word W_IDBASE + i
    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0: return 8'h11;
            3'd1: return 8'h10;
            3'd2: return 8'h14;
            3'd3: return 8'h00;
            3'd4: return 8'h0D;
            3'd5: return 8'hF0;
            3'd6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/uirq_regs.sv
// Module: uirq_regs
// Holds the register state: raw status, enable mask, the two divisors and the FIFO level.
// Assumes one write per cycle on a word index. In the same cycle, a set from an event or a transmit write wins over a clear.
module uirq_regs
    import uirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WIDX_W-1:0]    widx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SRC-1:0]   evt_set,
    output logic [NUM_SRC-1:0]   raw_q,
    output logic [NUM_SRC-1:0]   mask_q,
    output logic [IDIV_W-1:0]    idiv_q,
    output logic [FDIV_W-1:0]    fdiv_q,
    output logic [LVL_W-1:0]     lvl_q
);
    logic [NUM_SRC-1:0] clr_bits;
    logic [NUM_SRC-1:0] set_bits;

    // Decode the clear request and the set request for this cycle
    always_comb begin
        clr_bits = '0;
        set_bits = evt_set;
        if (wr_en && widx == W_CLR)    clr_bits = wdata[NUM_SRC-1:0];
        if (wr_en && widx == W_TXDATA) set_bits[B_TX] = 1'b1;
    end

    // Sticky raw status: clear first, then OR in the sets
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_bits) | set_bits;
    end

    // Software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            idiv_q <= '0;
            fdiv_q <= '0;
            lvl_q  <= LVL_RESET;
        end else if (wr_en) begin
            case (widx)
                W_MASK: mask_q <= wdata[NUM_SRC-1:0];
                W_IDIV: idiv_q <= wdata[IDIV_W-1:0];
                W_FDIV: fdiv_q <= wdata[FDIV_W-1:0];
                W_LVL:  lvl_q  <= wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uirq_irq_out.sv
// Module: uirq_irq_out
// Registers one interrupt line per class and one combined line from raw AND mask.
// Assumes every source bit belongs to exactly one class.
module uirq_irq_out
    import uirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   raw_q,
    input  logic [NUM_SRC-1:0]   mask_q,
    output logic [NUM_CLS-1:0]   irq_cls,
    output logic                 irq_all
);
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] all_mask;

    // Masked view and the union of every class mask
    always_comb begin
        active   = raw_q & mask_q;
        all_mask = '0;
        for (int c = 0; c < NUM_CLS; c++) all_mask = all_mask | class_mask(c);
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        localparam logic [NUM_SRC-1:0] CMASK = class_mask(c);
        // Per-class output flop
        always_ff @(posedge clk) begin
            if (!rst_n) irq_cls[c] <= 1'b0;
            else        irq_cls[c] <= |(active & CMASK);
        end
    end

    // Combined output flop
    always_ff @(posedge clk) begin
        if (!rst_n) irq_all <= 1'b0;
        else        irq_all <= |(active & all_mask);
    end
endmodule

// File: rtl/uirq_rdmux.sv
// Module: uirq_rdmux
// Selects the read data for a word index without a clock. Reads have no side effects.
// Assumes that unmapped words and write-only words read as zero.
module uirq_rdmux
    import uirq_pkg::*;
(
    input  logic [WIDX_W-1:0]    widx,
    input  logic [NUM_SRC-1:0]   raw_q,
    input  logic [NUM_SRC-1:0]   mask_q,
    input  logic [IDIV_W-1:0]    idiv_q,
    input  logic [FDIV_W-1:0]    fdiv_q,
    input  logic [LVL_W-1:0]     lvl_q,
    output logic [DATA_W-1:0]    rdata
);
    // Read data selection
    always_comb begin
        rdata = '0;
        case (widx)
            W_MASK:   rdata[NUM_SRC-1:0] = mask_q;
            W_RAW:    rdata[NUM_SRC-1:0] = raw_q;
            W_MASKED: rdata[NUM_SRC-1:0] = raw_q & mask_q;
            W_IDIV:   rdata[IDIV_W-1:0]  = idiv_q;
            W_FDIV:   rdata[FDIV_W-1:0]  = fdiv_q;
            W_LVL:    rdata[LVL_W-1:0]   = lvl_q;
            default: begin
                if (widx >= W_IDBASE) rdata[7:0] = id_byte(widx[2:0]);
            end
        endcase
    end
endmodule

// File: rtl/uirq_unit.sv
// Module: uirq_unit (top)
// The interrupt register group of a UART-style peripheral: sticky raw status, enable mask, masked view, write-one-to-clear register,
// divisor and level registers, identification bytes, and six registered interrupt lines.
// Assumes that the bus presents a word-aligned byte address and a write strobe of one cycle.
module uirq_unit
    import uirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [10:0]        evt_set,
    output logic               irq_all,
    output logic               irq_rx,
    output logic               irq_tx,
    output logic               irq_rt,
    output logic               irq_ms,
    output logic               irq_err
);
    logic [WIDX_W-1:0]  widx;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [IDIV_W-1:0]  idiv_q;
    logic [FDIV_W-1:0]  fdiv_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [NUM_CLS-1:0] irq_cls;

    assign widx = bus_addr[ADDR_W-1:2];

    uirq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .widx(widx), .wdata(bus_wdata),
        .evt_set(evt_set), .raw_q(raw_q), .mask_q(mask_q), .idiv_q(idiv_q),
        .fdiv_q(fdiv_q), .lvl_q(lvl_q)
    );

    uirq_irq_out u_out (
        .clk(clk), .rst_n(rst_n), .raw_q(raw_q), .mask_q(mask_q),
        .irq_cls(irq_cls), .irq_all(irq_all)
    );

    uirq_rdmux u_rd (
        .widx(widx), .raw_q(raw_q), .mask_q(mask_q), .idiv_q(idiv_q),
        .fdiv_q(fdiv_q), .lvl_q(lvl_q), .rdata(bus_rdata)
    );

    assign irq_rx  = irq_cls[CLS_RX];
    assign irq_tx  = irq_cls[CLS_TX];
    assign irq_rt  = irq_cls[CLS_RT];
    assign irq_ms  = irq_cls[CLS_MS];
    assign irq_err = irq_cls[CLS_ERR];
endmodule

// File: rtl/uirq_unit_chk.sv
// Module: uirq_unit_chk
// Checks the timing and status rules of uirq_unit with properties. It is bound into every instance of the top.
module uirq_unit_chk
    import uirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_rdata,
    input  logic [10:0]        evt_set,
    input  logic [10:0]        raw_q,
    input  logic [10:0]        mask_q,
    input  logic               irq_all,
    input  logic               irq_rx,
    input  logic               irq_tx,
    input  logic               irq_rt,
    input  logic               irq_ms,
    input  logic               irq_err
);
    AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));                // R2
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:2] == W_CLR) |-> (bus_rdata == 32'h0));                          // R4
    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr[11:2] == W_RAW || bus_addr[11:2] == W_MASKED) && evt_set == '0)
        |=> $stable(raw_q));                                                          // R5
    AST_TX_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[11:2] == W_TXDATA) |=> raw_q[B_TX]);                      // R6
    AST_RX_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_rx == $past(raw_q[B_RX] & mask_q[B_RX])));                      // R7
    AST_ALL_UNION: assert property (@(posedge clk) disable iff (!rst_n)
        irq_all == (irq_rx | irq_tx | irq_rt | irq_ms | irq_err));                   // R7
    AST_ID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'hFE0) |-> (bus_rdata == 32'h11));                             // R9
endmodule

bind uirq_unit uirq_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .raw_q(raw_q), .mask_q(mask_q), .irq_all(irq_all), .irq_rx(irq_rx),
    .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
);

// File: tb/uirq_unit_tb.sv
module uirq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] evt_set = '0;
    logic irq_all, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uirq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_set(evt_set), .irq_all(irq_all), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [10:0] evt;
        logic [11:0] raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h010, 32'h0000_07FF, 11'h000, 12'h010, 32'h0000_07FF}, // R3 mask write
        '{1'b0, 12'h000, 32'h0,         11'h001, 12'h014, 32'h0000_0001}, // R2 event sets
        '{1'b0, 12'h000, 32'h0,         11'h004, 12'h014, 32'h0000_0005}, // R2 sticky
        '{1'b1, 12'h010, 32'h0000_0004, 11'h000, 12'h018, 32'h0000_0004}, // R3 masked view
        '{1'b1, 12'h014, 32'h0000_07FF, 11'h000, 12'h014, 32'h0000_0005}, // R5 raw write
        '{1'b1, 12'h018, 32'h0000_0000, 11'h000, 12'h014, 32'h0000_0005}, // R5 masked write
        '{1'b1, 12'h01C, 32'h0000_0001, 11'h000, 12'h014, 32'h0000_0004}, // R4 clear one
        '{1'b1, 12'h000, 32'h0000_0041, 11'h000, 12'h014, 32'h0000_0006}, // R6 tx write
        '{1'b1, 12'h01C, 32'hFFFF_FFFF, 11'h000, 12'h014, 32'h0000_0000}, // R4 clear all
        '{1'b1, 12'h020, 32'h0001_2345, 11'h000, 12'h020, 32'h0000_2345}, // R10 int divisor
        '{1'b1, 12'h024, 32'h0000_00FF, 11'h000, 12'h024, 32'h0000_003F}, // R10 frac divisor
        '{1'b1, 12'h100, 32'h0000_0005, 11'h000, 12'h100, 32'h0000_0000}, // R11 unmapped
        '{1'b0, 12'h000, 32'h0,         11'h000, 12'hFE0, 32'h0000_0011}, // R9 first id
        '{1'b0, 12'h000, 32'h0,         11'h000, 12'hFFC, 32'h0000_00B1}  // R9 last id
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // One bus cycle: inputs held across one posedge, then released
    task automatic op(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic [10:0] e);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_set = e;
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [31:0] irqv();
        return {26'h0, irq_all, irq_err, irq_ms, irq_rt, irq_tx, irq_rx};
    endfunction

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(12'h014, v); check("R1 raw", v, 32'h0);
        rd(12'h010, v); check("R1 mask", v, 32'h0);
        rd(12'h028, v); check("R1 level", v, 32'h12);
        rd(12'h020, v); check("R1 idiv", v, 32'h0);
        check("R1 outputs", irqv(), 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].evt);
            rd(VECS[i].raddr, v);
            check($sformatf("table vector %0d", i), v, VECS[i].exp);
        end

        // R7 error class: output lags raw by one clock
        op(1'b1, 12'h010, 32'h7FF, 11'h0);
        op(1'b0, 12'h000, 32'h0, 11'h008);
        check("R7 before lag", irqv(), 32'h0);
        @(negedge clk);
        check("R7 error line", irqv(), 32'h30);
        // R7 modem class
        op(1'b1, 12'h01C, 32'h7FF, 11'h0);
        @(negedge clk);
        op(1'b0, 12'h000, 32'h0, 11'h080);
        @(negedge clk);
        check("R7 modem line", irqv(), 32'h28);
        // R7 receive timeout class
        op(1'b0, 12'h000, 32'h0, 11'h004);
        @(negedge clk);
        check("R7 timeout plus modem", irqv(), 32'h2C);
        // R8 mask write drops outputs one clock after mask update
        op(1'b1, 12'h010, 32'h0, 11'h0);
        check("R8 before lag", irqv(), 32'h2C);
        @(negedge clk);
        check("R8 masked off", irqv(), 32'h0);
        // R4 set wins over clear in the same cycle
        op(1'b1, 12'h01C, 32'h7FF, 11'h0);
        op(1'b1, 12'h01C, 32'h001, 11'h001);
        rd(12'h014, v); check("R4 set wins", v, 32'h1);
        rd(12'h01C, v); check("R4 clear reads 0", v, 32'h0);
        // R6 transmit line via data write
        op(1'b1, 12'h010, 32'h002, 11'h0);
        op(1'b1, 12'h000, 32'h55, 11'h0);
        @(negedge clk);
        check("R6 tx line", irqv(), 32'h22);
        // R9 middle id byte, R11 unmapped write left no trace in mapped registers
        rd(12'hFF0, v); check("R9 id byte 4", v, 32'h0D);
        rd(12'h028, v); check("R11 level unchanged", v, 32'h12);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule